// File: doc/BRIEF.md
# Switching-Cycle Fault Event Accumulator

This block judges one protection condition of a switching power stage, once per switching cycle. It watches a comparator output that has already been sampled into the clock domain. It also watches two single-cycle strobes that mark the gate drive turning on and turning off. From these it decides whether the cycle counts as a fault event, and it moves a saturating up/down counter by one step. A fault is declared when the counter reaches a programmed limit. This averages out isolated glitches that a single comparator trip would otherwise turn into a shutdown.

One of three checks is selected by a mode field:

- **Overvoltage:** the comparator matters only while the gate is off.
- **Overcurrent:** the comparator matters only while the gate is on.
- **Open loop:** the sense is inverted. A cycle counts as an event when the comparator stays quiet for a short scan window that follows the blanking time after gate turn-on.

Once a fault is declared, the block does one of two things. It can hold the fault until reset. Or it can run a restart timer, built on a prescaled timebase with a slow option, and then resume with a cleared counter. A shutdown select decides whether the gate-enable output is forced low during the fault. All configuration arrives as static inputs.

Top module: `swc_fault_accum`

## Requirements
- R1: After reset, `evt_count` is 0, `fault` is 0 and `gate_en` is 1.
- R2: While `prot_dis` is 1, or `mode_sel` is 2'b11, and no fault is active, the counter is forced to 0 and no fault is declared.
- R3: With `mode_sel` = 2'b01 (overcurrent), a comparator high counts only in cycles after a `gate_on_stb` and before the next `gate_off_stb`. A cycle counts only once its elapsed index (0 for the first cycle after the strobe) is at least `blank_sel`*2. The counter moves only on the `gate_off_stb` edge: +1 if such a trip occurred in that on phase, otherwise −1.
- R4: With `mode_sel` = 2'b00 (overvoltage), the same rule applies to the off phase (after `gate_off_stb`, with blanking measured from it). The counter moves only on the next `gate_on_stb` edge.
- R5: With `mode_sel` = 2'b10 (open loop), the counter moves on the `gate_off_stb` edge. It goes −1 if the comparator was high at any on-phase index in [`blank_sel`*2, `blank_sel`*2+4), and +1 otherwise. Trips outside that window are ignored.
- R6: The counter changes by at most one per update and never wraps below 0 or above its maximum.
- R7: A fault is declared on the same edge that updates the counter to a value greater than or equal to `cnt_limit`.
- R8: With `latch_en` = 1, a declared fault stays asserted and the counter stays frozen until reset.
- R9: With `latch_en` = 0, `fault` stays high for exactly (`restart_val`+1)×8 cycles, or (`restart_val`+1)×32 cycles when `slow_sel` = 1. It then drops with the counter cleared to 0.
- R10: `gate_en` is 0 while `fault` is 1 and `shdn_sel` is 1; otherwise `gate_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_in | input | 1 | Sampled protection comparator output |
| gate_on_stb | input | 1 | One-cycle strobe: gate drive turns on |
| gate_off_stb | input | 1 | One-cycle strobe: gate drive turns off |
| prot_dis | input | 1 | 1 disables the protection |
| mode_sel | input | 2 | 00 overvoltage, 01 overcurrent, 10 open loop, 11 off |
| blank_sel | input | 3 | Blanking length in units of 2 cycles |
| cnt_limit | input | 3 | Counter value that declares a fault |
| latch_en | input | 1 | 1 holds the fault until reset |
| restart_val | input | 6 | Restart delay in prescaled ticks, minus one |
| slow_sel | input | 1 | 1 selects a 4× slower restart timebase |
| shdn_sel | input | 1 | 1 forces the gate enable low during a fault |
| fault | output | 1 | Fault state active |
| gate_en | output | 1 | Gate drive permitted |
| evt_count | output | 4 | Current event counter value |

## Verification
The bench places comparator pulses on the last blanked index and on the first qualified index. A window off by one cycle would count the blanked trip, or miss the qualified one. In open-loop mode the bench trips just past the scan window, where a design that forgot the window's end would count down instead of up. In overvoltage mode it checks the counter before and after the following turn-on strobe, so a design that evaluates at turn-off shows a stale count. It also times the fault-high interval of a restart on both timebases to the exact cycle, checks that a latched fault freezes the counter, and checks that the counter sits at zero after a restart and under a decrement from zero.

// File: rtl/swc_fault_pkg.sv
// Shared encodings for the switching-cycle fault accumulator.
package swc_fault_pkg;

    // Protection check selected by the mode field.
    typedef enum logic [1:0] {
        MODE_OV  = 2'b00,
        MODE_OC  = 2'b01,
        MODE_OL  = 2'b10,
        MODE_OFF = 2'b11
    } prot_mode_e;

    // Top-level protection state.
    typedef enum logic [1:0] {
        ST_RUN     = 2'b00,
        ST_LATCHED = 2'b01,
        ST_RESTART = 2'b10
    } fstate_e;

endpackage

// File: rtl/swc_qual_window.sv
// Qualification window tracker.
// Tracks which phase (gate on / gate off) the converter is in and how many
// cycles have elapsed since the last gate strobe. From the selected mode and
// the blanking length it decides in which cycles the comparator counts, and
// it reports one verdict per switching cycle on the evaluating strobe.
// Assumes: strobes are single-cycle pulses; if both fire together, turn-on wins.
module swc_qual_window
    import swc_fault_pkg::*;
#(
    parameter int BLK_W      = 3,
    parameter int BLANK_STEP = 2,
    parameter int SCAN_LEN   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    input  logic             gate_on_stb,
    input  logic             gate_off_stb,
    input  prot_mode_e       mode,
    input  logic [BLK_W-1:0] blank_sel,
    output logic             eval_vld,
    output logic             eval_up
);

    localparam int MAX_ELAP = ((1 << BLK_W) - 1) * BLANK_STEP + SCAN_LEN;
    localparam int ELAP_W   = $clog2(MAX_ELAP + 1);
    localparam int CMP_W    = ELAP_W + 1;

    logic              on_phase_q;
    logic [ELAP_W-1:0] elap_q;
    logic              trip_q;
    logic [CMP_W-1:0]  blank_len;
    logic [CMP_W-1:0]  scan_end;
    logic [CMP_W-1:0]  elap_ext;
    logic              past_blank;
    logic              in_scan;
    logic              any_stb;
    logic              qualify;

    // Window bounds derived from the blanking field.
    always_comb begin
        blank_len  = CMP_W'(int'(blank_sel) * BLANK_STEP);
        scan_end   = blank_len + CMP_W'(SCAN_LEN);
        elap_ext   = {1'b0, elap_q};
        past_blank = (elap_ext >= blank_len);
        in_scan    = (elap_ext < scan_end);
        any_stb    = gate_on_stb | gate_off_stb;
    end

    // Per-mode qualification of the current cycle.
    always_comb begin
        qualify = 1'b0;
        if (!any_stb && past_blank) begin
            unique case (mode)
                MODE_OV: qualify = !on_phase_q;
                MODE_OC: qualify = on_phase_q;
                MODE_OL: qualify = on_phase_q && in_scan;
                default: qualify = 1'b0;
            endcase
        end
    end

    // Phase, elapsed-cycle and trip-seen tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_phase_q <= 1'b0;
            elap_q     <= '0;
            trip_q     <= 1'b0;
        end else if (any_stb) begin
            on_phase_q <= gate_on_stb;
            elap_q     <= '0;
            trip_q     <= 1'b0;
        end else begin
            if (elap_q != ELAP_W'(MAX_ELAP)) begin
                elap_q <= elap_q + 1'b1;
            end
            trip_q <= trip_q | (qualify & cmp_in);
        end
    end

    // Verdict on the evaluating strobe of the selected mode.
    always_comb begin
        unique case (mode)
            MODE_OV: begin
                eval_vld = gate_on_stb;
                eval_up  = trip_q;
            end
            MODE_OC: begin
                eval_vld = gate_off_stb && !gate_on_stb;
                eval_up  = trip_q;
            end
            MODE_OL: begin
                eval_vld = gate_off_stb && !gate_on_stb;
                eval_up  = !trip_q;
            end
            default: begin
                eval_vld = 1'b0;
                eval_up  = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/swc_event_counter.sv
// Saturating up/down event counter.
// Steps by one per valid verdict, clamps at zero and at all-ones.
// Clear has priority over hold, and hold has priority over a step.
// Also exposes the next value, so a caller can compare it in the same cycle.
module swc_event_counter #(
    parameter int ACC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             hold,
    input  logic             step_vld,
    input  logic             step_up,
    output logic [ACC_W-1:0] count,
    output logic [ACC_W-1:0] count_nxt
);

    localparam logic [ACC_W-1:0] CNT_MAX = {ACC_W{1'b1}};

    logic [ACC_W-1:0] cnt_q;

    // Next-value selection with saturation at both ends.
    always_comb begin
        count_nxt = cnt_q;
        if (clear) begin
            count_nxt = '0;
        end else if (!hold && step_vld) begin
            if (step_up) begin
                count_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
            end else begin
                count_nxt = (cnt_q == '0) ? cnt_q : cnt_q - 1'b1;
            end
        end
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= count_nxt;
        end
    end

    assign count = cnt_q;

endmodule

// File: rtl/swc_restart_timer.sv
// Restart delay timer.
// On start it counts (restart_val+1) ticks. Each tick is PRESCALE clock
// cycles, or PRESCALE << SLOW_SHIFT cycles when slow_sel is 1. It raises done
// for one cycle on the last clock of the last tick.
// Assumes: restart_val and slow_sel are static while the timer is busy.
module swc_restart_timer #(
    parameter int PRESCALE   = 8,
    parameter int SLOW_SHIFT = 2,
    parameter int RST_W      = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [RST_W-1:0] restart_val,
    input  logic             slow_sel,
    output logic             busy,
    output logic             done
);

    localparam int SLOW_PER = PRESCALE << SLOW_SHIFT;
    localparam int PRE_W    = (SLOW_PER > 1) ? $clog2(SLOW_PER) : 1;

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_last;
    logic [RST_W-1:0] tick_q;
    logic             busy_q;
    logic             tick_end;

    // Last prescaler value; the slow variant only exists when it differs.
    generate
        if (SLOW_SHIFT == 0) begin : g_single_base
            assign pre_last = PRE_W'(PRESCALE - 1);
        end else begin : g_dual_base
            assign pre_last = slow_sel ? PRE_W'(SLOW_PER - 1) : PRE_W'(PRESCALE - 1);
        end
    endgenerate

    // Tick and completion detection.
    always_comb begin
        tick_end = busy_q && (pre_q == pre_last);
        done     = tick_end && (tick_q == restart_val);
    end

    // Prescaler, tick counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            pre_q  <= '0;
            tick_q <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            pre_q  <= '0;
            tick_q <= '0;
        end else if (busy_q) begin
            if (tick_end) begin
                pre_q <= '0;
                if (done) begin
                    busy_q <= 1'b0;
                end else begin
                    tick_q <= tick_q + 1'b1;
                end
            end else begin
                pre_q <= pre_q + 1'b1;
            end
        end
    end

    assign busy = busy_q;

endmodule

// File: rtl/swc_fault_accum.sv
// Switching-cycle fault event accumulator (top).
// Combines the qualification window, the event counter and the restart
// timer. A fault is declared when an update brings the counter to
// cnt_limit or above. The fault then either latches or runs the restart
// timer, after which the counter is cleared.
// Assumes: configuration inputs are static; cmp_in is already synchronous.
module swc_fault_accum
    import swc_fault_pkg::*;
#(
    parameter int ACC_W      = 4,
    parameter int LIM_W      = 3,
    parameter int BLK_W      = 3,
    parameter int RST_W      = 6,
    parameter int BLANK_STEP = 2,
    parameter int SCAN_LEN   = 4,
    parameter int PRESCALE   = 8,
    parameter int SLOW_SHIFT = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_in,
    input  logic             gate_on_stb,
    input  logic             gate_off_stb,
    input  logic             prot_dis,
    input  logic [1:0]       mode_sel,
    input  logic [BLK_W-1:0] blank_sel,
    input  logic [LIM_W-1:0] cnt_limit,
    input  logic             latch_en,
    input  logic [RST_W-1:0] restart_val,
    input  logic             slow_sel,
    input  logic             shdn_sel,
    output logic             fault,
    output logic             gate_en,
    output logic [ACC_W-1:0] evt_count
);

    prot_mode_e       mode;
    fstate_e          state_q;
    fstate_e          state_d;
    logic             enabled;
    logic             in_run;
    logic             eval_vld;
    logic             eval_up;
    logic             step_vld;
    logic             acc_clear;
    logic             fault_hit;
    logic             rs_start;
    logic             rs_busy;
    logic             rs_done;
    logic [ACC_W-1:0] count_nxt;

    // Decode the mode and the enable (enable bit is active low).
    always_comb begin
        mode    = prot_mode_e'(mode_sel);
        enabled = !prot_dis && (mode != MODE_OFF);
        in_run  = (state_q == ST_RUN);
    end

    swc_qual_window #(
        .BLK_W      (BLK_W),
        .BLANK_STEP (BLANK_STEP),
        .SCAN_LEN   (SCAN_LEN)
    ) u_window (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_in       (cmp_in),
        .gate_on_stb  (gate_on_stb),
        .gate_off_stb (gate_off_stb),
        .mode         (mode),
        .blank_sel    (blank_sel),
        .eval_vld     (eval_vld),
        .eval_up      (eval_up)
    );

    // Counter control: clear when disabled or when a restart completes.
    always_comb begin
        step_vld  = eval_vld && enabled;
        acc_clear = (in_run && !enabled) || rs_done;
    end

    swc_event_counter #(
        .ACC_W (ACC_W)
    ) u_counter (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (acc_clear),
        .hold      (!in_run),
        .step_vld  (step_vld),
        .step_up   (eval_up),
        .count     (evt_count),
        .count_nxt (count_nxt)
    );

    // Fault declaration on the updating edge.
    always_comb begin
        fault_hit = in_run && step_vld && (count_nxt >= ACC_W'(cnt_limit));
        rs_start  = fault_hit && !latch_en;
    end

    swc_restart_timer #(
        .PRESCALE   (PRESCALE),
        .SLOW_SHIFT (SLOW_SHIFT),
        .RST_W      (RST_W)
    ) u_restart (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (rs_start),
        .restart_val (restart_val),
        .slow_sel    (slow_sel),
        .busy        (rs_busy),
        .done        (rs_done)
    );

    // Next-state selection for the protection state.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (fault_hit) begin
                    state_d = latch_en ? ST_LATCHED : ST_RESTART;
                end
            end
            ST_RESTART: begin
                if (rs_done || !rs_busy) begin
                    state_d = ST_RUN;
                end
            end
            ST_LATCHED: state_d = ST_LATCHED;
            default:    state_d = ST_RUN;
        endcase
    end

    // Protection state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        fault   = !in_run;
        gate_en = !(fault && shdn_sel);
    end

endmodule

// File: rtl/swc_fault_accum_chk.sv
// Assertion checker for swc_fault_accum, attached through bind.
module swc_fault_accum_chk #(
    parameter int ACC_W = 4,
    parameter int LIM_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             gate_on_stb,
    input logic             gate_off_stb,
    input logic             prot_dis,
    input logic [1:0]       mode_sel,
    input logic [LIM_W-1:0] cnt_limit,
    input logic             latch_en,
    input logic             shdn_sel,
    input logic             fault,
    input logic             gate_en,
    input logic [ACC_W-1:0] evt_count
);

    // R6
    step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_count > $past(evt_count)) |-> (evt_count == $past(evt_count) + 1'b1));

    // R10
    shdn_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && shdn_sel) |-> !gate_en);

    // R10
    run_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault |-> gate_en);

    // R8
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && latch_en) |=> (fault && $stable(evt_count)));

    // R7
    fault_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fault) |-> (evt_count >= ACC_W'(cnt_limit)));

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> (evt_count == '0));

    // R2
    disabled_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault && (prot_dis || mode_sel == 2'b11)) |=> (evt_count == '0 && !fault));

    // R3
    oc_update_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel) == 2'b01 && !$past(prot_dis) && !$past(gate_off_stb) && !$fell(fault))
        |-> $stable(evt_count));

    // R4
    ov_update_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode_sel) == 2'b00 && !$past(prot_dis) && !$past(gate_on_stb) && !$fell(fault))
        |-> $stable(evt_count));

endmodule

bind swc_fault_accum swc_fault_accum_chk #(
    .ACC_W (ACC_W),
    .LIM_W (LIM_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_on_stb  (gate_on_stb),
    .gate_off_stb (gate_off_stb),
    .prot_dis     (prot_dis),
    .mode_sel     (mode_sel),
    .cnt_limit    (cnt_limit),
    .latch_en     (latch_en),
    .shdn_sel     (shdn_sel),
    .fault        (fault),
    .gate_en      (gate_en),
    .evt_count    (evt_count)
);

// File: tb/swc_fault_accum_test.sv
`timescale 1ns/1ps
// Directed bench for swc_fault_accum: one task per scenario.
module swc_fault_accum_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_in = 1'b0;
    logic       gate_on_stb = 1'b0;
    logic       gate_off_stb = 1'b0;
    logic       prot_dis = 1'b0;
    logic [1:0] mode_sel = 2'b01;
    logic [2:0] blank_sel = 3'd0;
    logic [2:0] cnt_limit = 3'd7;
    logic       latch_en = 1'b1;
    logic [5:0] restart_val = 6'd0;
    logic       slow_sel = 1'b0;
    logic       shdn_sel = 1'b0;
    logic       fault;
    logic       gate_en;
    logic [3:0] evt_count;

    int n_tests = 0;
    int n_fail  = 0;
    int hi_cnt  = 0;
    bit done    = 1'b0;

    swc_fault_accum uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmp_in       (cmp_in),
        .gate_on_stb  (gate_on_stb),
        .gate_off_stb (gate_off_stb),
        .prot_dis     (prot_dis),
        .mode_sel     (mode_sel),
        .blank_sel    (blank_sel),
        .cnt_limit    (cnt_limit),
        .latch_en     (latch_en),
        .restart_val  (restart_val),
        .slow_sel     (slow_sel),
        .shdn_sel     (shdn_sel),
        .fault        (fault),
        .gate_en      (gate_en),
        .evt_count    (evt_count)
    );

    // 125 MHz clock.
    always #4 clk = ~clk;

    // Counts the samples with fault high, for restart timing.
    always @(negedge clk) if (rst_n && fault) hi_cnt++;

    task automatic check(string req, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cmp_in = 1'b0; gate_on_stb = 1'b0; gate_off_stb = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        hi_cnt = 0;
    endtask

    // One switching cycle; a trip index of -1 means no comparator pulse.
    task automatic run_cycle(int on_len, int off_len, int on_trip, int off_trip);
        @(negedge clk);
        gate_on_stb = 1'b1; cmp_in = 1'b0;
        @(negedge clk);
        gate_on_stb = 1'b0;
        for (int i = 0; i < on_len; i++) begin
            cmp_in = (i == on_trip);
            @(negedge clk);
        end
        cmp_in = 1'b0; gate_off_stb = 1'b1;
        @(negedge clk);
        gate_off_stb = 1'b0;
        for (int i = 0; i < off_len; i++) begin
            cmp_in = (i == off_trip);
            @(negedge clk);
        end
        cmp_in = 1'b0;
    endtask

    task automatic wait_fault_clear();
        for (int i = 0; i < 2000 && fault; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        mode_sel = 2'b01; prot_dis = 1'b0;
        do_reset();
        @(negedge clk);
        check("R1 count", evt_count, 0);
        check("R1 fault", fault, 0);
        check("R1 gate_en", gate_en, 1);
    endtask

    task automatic test_overcurrent();
        mode_sel = 2'b01; blank_sel = 3'd1; cnt_limit = 3'd3;
        latch_en = 1'b1; shdn_sel = 1'b1; prot_dis = 1'b0;
        do_reset();
        run_cycle(6, 4, -1, -1);
        check("R6 down from zero", evt_count, 0);
        run_cycle(6, 4, 3, -1);
        check("R3 qualified trip", evt_count, 1);
        run_cycle(6, 4, 1, -1);
        check("R3 blanked trip ignored", evt_count, 0);
        run_cycle(6, 4, 2, -1);
        check("R3 first qualified index", evt_count, 1);
        run_cycle(6, 4, -1, 1);
        check("R3 off-time trip ignored", evt_count, 0);
        run_cycle(6, 4, 5, -1);
        run_cycle(6, 4, 5, -1);
        check("R7 below limit count", evt_count, 2);
        check("R7 below limit fault", fault, 0);
        run_cycle(6, 4, 4, -1);
        check("R7 fault at limit", fault, 1);
        check("R10 gate_en off", gate_en, 0);
        run_cycle(6, 4, -1, -1);
        check("R8 latched fault", fault, 1);
        check("R8 frozen count", evt_count, 3);
    endtask

    task automatic test_overvoltage();
        mode_sel = 2'b00; blank_sel = 3'd0; cnt_limit = 3'd2;
        latch_en = 1'b0; shdn_sel = 1'b0; restart_val = 6'd2; slow_sel = 1'b0;
        prot_dis = 1'b0;
        do_reset();
        run_cycle(4, 4, 1, 0);
        check("R4 no update before next turn-on", evt_count, 0);
        run_cycle(4, 4, -1, -1);
        check("R4 update at turn-on", evt_count, 1);
        run_cycle(4, 4, -1, 2);
        check("R4 clean off phase", evt_count, 0);
        run_cycle(4, 4, -1, 3);
        check("R4 update after late trip", evt_count, 1);
        @(negedge clk); gate_on_stb = 1'b1;
        @(negedge clk); gate_on_stb = 1'b0;
        check("R7 fault declared", fault, 1);
        check("R7 count at limit", evt_count, 2);
        check("R10 gate_en kept", gate_en, 1);
        wait_fault_clear();
        check("R9 fast restart length", hi_cnt, 24);
        check("R9 count cleared", evt_count, 0);
    endtask

    task automatic test_slow_restart();
        mode_sel = 2'b01; blank_sel = 3'd0; cnt_limit = 3'd1;
        latch_en = 1'b0; shdn_sel = 1'b1; restart_val = 6'd1; slow_sel = 1'b1;
        prot_dis = 1'b0;
        do_reset();
        run_cycle(4, 2, 2, -1);
        check("R7 single event fault", fault, 1);
        check("R10 gate_en off in restart", gate_en, 0);
        wait_fault_clear();
        check("R9 slow restart length", hi_cnt, 64);
        check("R9 cleared after slow restart", evt_count, 0);
        check("R10 gate_en back", gate_en, 1);
    endtask

    task automatic test_open_loop();
        mode_sel = 2'b10; blank_sel = 3'd1; cnt_limit = 3'd7;
        latch_en = 1'b1; prot_dis = 1'b0;
        do_reset();
        run_cycle(8, 2, -1, -1);
        check("R5 silent cycle up", evt_count, 1);
        run_cycle(8, 2, 3, -1);
        check("R5 trip in window down", evt_count, 0);
        run_cycle(8, 2, 6, -1);
        check("R5 trip after window ignored", evt_count, 1);
        run_cycle(8, 2, 1, -1);
        check("R5 blanked trip ignored", evt_count, 2);
        run_cycle(8, 2, 5, -1);
        check("R5 last window index", evt_count, 1);
        run_cycle(8, 2, 2, -1);
        check("R5 first window index", evt_count, 0);
    endtask

    task automatic test_disable();
        mode_sel = 2'b01; blank_sel = 3'd0; cnt_limit = 3'd2;
        latch_en = 1'b1; prot_dis = 1'b1;
        do_reset();
        run_cycle(4, 2, 1, -1);
        run_cycle(4, 2, 1, -1);
        check("R2 disabled count", evt_count, 0);
        check("R2 disabled fault", fault, 0);
        prot_dis = 1'b0; mode_sel = 2'b11;
        run_cycle(4, 2, 1, -1);
        run_cycle(4, 2, 1, -1);
        check("R2 off mode count", evt_count, 0);
        mode_sel = 2'b01;
        run_cycle(4, 2, 1, -1);
        check("R2 re-enabled count", evt_count, 1);
        check("R2 re-enabled fault", fault, 0);
    endtask

    initial begin
        test_reset();
        test_overcurrent();
        test_overvoltage();
        test_slow_restart();
        test_open_loop();
        test_disable();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule